// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

The sequencer refills one cache line across a memory bus that carries fewer words per transfer than the line holds. A miss request names the line and the word the stalled processor needs. The sequencer issues a single burst read whose address points at the doubleword that holds that word. It then takes four data beats, each qualified by a valid strobe. The bus may insert any number of idle cycles between beats, so the block runs entirely in the bus clock domain.

The beats arrive in wrap-around order, starting at the critical doubleword. Each beat is written straight into the line buffer at the doubleword slot it belongs to. When the first beat arrives, the block pulses an early-restart strobe carrying the requested 32-bit word, so the processor can resume before the rest of the line lands. A one-cycle line-valid strobe follows the final beat. A new miss is accepted only after that strobe.

Top module: `cwf_fill_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and bus_req_o, lb_we_o, restart_o and line_valid_o are all 0.
- R2: The cycle after a miss is accepted, bus_req_o rises with bus_addr_o = {line, word>>1, 3'b000}, that is line*32 + (word>>1)*8. Both stay unchanged until the cycle in which bus_ack_i is sampled high.
- R3: Beat k (k = 0..3) of a fill is written in the same cycle as its bus_dvalid_i. lb_idx_o = ((word>>1)+k) mod 4, and lb_data_o = bus_data_i. Bits 31:0 hold the even word of the doubleword and bits 63:32 hold the odd word.
- R4: bus_dvalid_i has no effect while idle or while the address phase is pending. lb_we_o stays 0 and no beat is counted.
- R5: Cycles with bus_dvalid_i low in the data phase write nothing and do not advance the beat order.
- R6: restart_o pulses in the cycle of the first beat only. restart_word_o is bus_data_i[31:0] when the word index is even and bus_data_i[63:32] when it is odd.
- R7: Each fill produces exactly one restart_o pulse.
- R8: line_valid_o is high for exactly one cycle, the cycle after the fourth beat is written.
- R9: req_ready_o is 0 from acceptance through the line_valid_o cycle, and requests offered in that time are ignored. req_ready_o returns to 1 in the cycle after line_valid_o.
- R10: Each fill writes exactly four beats, and each of the four doubleword slots is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request offered |
| req_ready_o | output | 1 | Sequencer idle, request taken when both are high |
| req_line_i | input | 27 | Line address (byte address bits 31:5) |
| req_word_i | input | 3 | Index of the requested word within the line |
| bus_req_o | output | 1 | Burst read address phase request |
| bus_addr_o | output | 32 | Byte address of the critical doubleword |
| bus_ack_i | input | 1 | Address phase accepted by the bus |
| bus_dvalid_i | input | 1 | Data beat present on bus_data_i |
| bus_data_i | input | 64 | Data beat |
| lb_we_o | output | 1 | Line buffer write strobe |
| lb_idx_o | output | 2 | Doubleword slot being written |
| lb_data_o | output | 64 | Doubleword written |
| restart_o | output | 1 | Critical word available |
| restart_word_o | output | 32 | Critical word |
| line_valid_o | output | 1 | Line fill complete |

## Verification
The assertions check three things on every cycle. First, the address phase holds its request and address until acknowledged. Second, no write is made while the address phase is pending, and every restart pulse coincides with a write. Third, line-valid is a single-cycle pulse that follows a write and never overlaps readiness. The slot order, the selected critical word, the exact address arithmetic and the once-per-slot coverage depend on the requested word. Only the bench's sweep over all eight word positions, several line addresses and varied wait patterns can show them.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } fill_st_e;
endpackage

// File: rtl/cwf_req_capture.sv
module cwf_req_capture #(
  parameter int LINE_AW = 27,
  parameter int WIDX_W  = 3,
  parameter int SUB_W   = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [LINE_AW-1:0]        line_i,
  input  logic [WIDX_W-1:0]         word_i,
  output logic [LINE_AW-1:0]        line_o,
  output logic [WIDX_W-SUB_W-1:0]   start_o,
  output logic [SUB_W-1:0]          sub_o
);
  logic [LINE_AW-1:0] line_q;
  logic [WIDX_W-1:0]  word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      word_q <= '0;
    end else if (load_i) begin
      line_q <= line_i;
      word_q <= word_i;
    end
  end

  assign line_o  = line_q;
  assign start_o = word_q[WIDX_W-1:SUB_W];
  assign sub_o   = word_q[SUB_W-1:0];
endmodule

// File: rtl/cwf_beat_ctr.sv
module cwf_beat_ctr #(
  parameter int BIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [BIDX_W-1:0] start_i,
  output logic [BIDX_W-1:0] idx_o,
  output logic              first_o,
  output logic              last_o
);
  logic [BIDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  // power-of-two beat count: wrap comes from width truncation
  assign idx_o   = start_i + cnt_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == {BIDX_W{1'b1}});

  AST_CTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !clr_i) |=> first_o); // R10
endmodule

// File: rtl/cwf_word_pick.sv
module cwf_word_pick #(
  parameter int WORD_W    = 32,
  parameter int BUS_WORDS = 2,
  localparam int SUB_W    = (BUS_WORDS > 1) ? $clog2(BUS_WORDS) : 1
) (
  input  logic [WORD_W*BUS_WORDS-1:0] data_i,
  input  logic [SUB_W-1:0]            sel_i,
  output logic [WORD_W-1:0]           word_o
);
  logic [WORD_W-1:0] lane [BUS_WORDS];

  for (genvar g = 0; g < BUS_WORDS; g++) begin : g_lane
    assign lane[g] = data_i[g*WORD_W +: WORD_W];
  end

  assign word_o = lane[sel_i];
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BUS_WORDS  = 2,
  localparam int BEATS      = LINE_WORDS / BUS_WORDS,
  localparam int BUS_W      = WORD_W * BUS_WORDS,
  localparam int WIDX_W     = $clog2(LINE_WORDS),
  localparam int BIDX_W     = $clog2(BEATS),
  localparam int SUB_W      = $clog2(BUS_WORDS),
  localparam int OFF_W      = $clog2(LINE_WORDS * WORD_W / 8),
  localparam int BEAT_OFF_W = $clog2(BUS_W / 8),
  localparam int LINE_AW    = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LINE_AW-1:0] req_line_i,
  input  logic [WIDX_W-1:0]  req_word_i,
  output logic               bus_req_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  input  logic               bus_ack_i,
  input  logic               bus_dvalid_i,
  input  logic [BUS_W-1:0]   bus_data_i,
  output logic               lb_we_o,
  output logic [BIDX_W-1:0]  lb_idx_o,
  output logic [BUS_W-1:0]   lb_data_o,
  output logic               restart_o,
  output logic [WORD_W-1:0]  restart_word_o,
  output logic               line_valid_o
);
  import cwf_pkg::*;

  fill_st_e st_q, st_d;
  logic              accept;
  logic              beat_we;
  logic              first_beat, last_beat;
  logic [LINE_AW-1:0] line_q;
  logic [BIDX_W-1:0] start_q;
  logic [SUB_W-1:0]  sub_q;

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign beat_we = (st_q == ST_DATA) && bus_dvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_ADDR;
      ST_ADDR: if (bus_ack_i) st_d = ST_DATA;
      ST_DATA: if (bus_dvalid_i && last_beat) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  cwf_req_capture #(
    .LINE_AW(LINE_AW), .WIDX_W(WIDX_W), .SUB_W(SUB_W)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .line_i (req_line_i),
    .word_i (req_word_i),
    .line_o (line_q),
    .start_o(start_q),
    .sub_o  (sub_q)
  );

  cwf_beat_ctr #(.BIDX_W(BIDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .step_i (beat_we),
    .start_i(start_q),
    .idx_o  (lb_idx_o),
    .first_o(first_beat),
    .last_o (last_beat)
  );

  cwf_word_pick #(.WORD_W(WORD_W), .BUS_WORDS(BUS_WORDS)) u_pick (
    .data_i(bus_data_i),
    .sel_i (sub_q),
    .word_o(restart_word_o)
  );

  assign req_ready_o  = (st_q == ST_IDLE);
  assign bus_req_o    = (st_q == ST_ADDR);
  assign bus_addr_o   = {line_q, start_q, {BEAT_OFF_W{1'b0}}};
  assign lb_we_o      = beat_we;
  assign lb_data_o    = bus_data_i;
  assign restart_o    = beat_we && first_beat;
  assign line_valid_o = (st_q == ST_DONE);

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o))); // R2
  AST_NO_WE_IN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o || req_ready_o) |-> !lb_we_o); // R4
  AST_RESTART_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (lb_we_o && lb_idx_o == start_q)); // R6
  AST_LV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |=> !line_valid_o); // R8
  AST_LV_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> $past(lb_we_o)); // R8
  AST_LV_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> !req_ready_o); // R9
  AST_READY_AFTER_LV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |=> req_ready_o); // R9
endmodule

// File: tb/sim_cwf_fill_seq.sv
module sim_cwf_fill_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [26:0] req_line = '0;
  logic [2:0]  req_word = '0;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic        bus_ack = 1'b0;
  logic        bus_dvalid = 1'b0;
  logic [63:0] bus_data = '0;
  logic        lb_we;
  logic [1:0]  lb_idx;
  logic [63:0] lb_data;
  logic        restart;
  logic [31:0] restart_word;
  logic        line_valid;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  cwf_fill_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_line_i(req_line), .req_word_i(req_word),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_ack_i(bus_ack),
    .bus_dvalid_i(bus_dvalid), .bus_data_i(bus_data),
    .lb_we_o(lb_we), .lb_idx_o(lb_idx), .lb_data_o(lb_data),
    .restart_o(restart), .restart_word_o(restart_word),
    .line_valid_o(line_valid)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(input logic [26:0] line, input int w);
    return 32'h1000_0000 + {1'b0, line, 4'b0} + w;
  endfunction

  function automatic logic [63:0] dw_val(input logic [26:0] line, input int d);
    return {word_val(line, 2*d+1), word_val(line, 2*d)};
  endfunction

  task automatic run_fill(input logic [26:0] line, input int word,
                          input int ack_wait, input int gap);
    int start;
    int restarts;
    logic [3:0] seen;
    logic [31:0] exp_addr;
    start = word / 2;
    restarts = 0;
    seen = '0;
    exp_addr = {line, 5'b0} + start * 8;

    @(negedge clk);
    req_valid = 1'b1; req_line = line; req_word = word[2:0];
    #2 chk(req_ready == 1'b1, "R9 ready before accept", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    // junk request and stray beats during the address phase
    req_line = ~line; req_word = ~word[2:0];
    for (int i = 0; i <= ack_wait; i++) begin
      bus_dvalid = 1'b1; bus_data = 64'hDEAD_BEEF_0BAD_F00D;
      bus_ack = (i == ack_wait);
      #2;
      chk(bus_req == 1'b1, "R2 bus_req held", 64'(bus_req), 64'd1);
      chk(bus_addr == exp_addr, "R2 bus_addr", 64'(bus_addr), 64'(exp_addr));
      chk(lb_we == 1'b0, "R4 no write in addr phase", 64'(lb_we), 64'd0);
      chk(req_ready == 1'b0, "R9 busy", 64'(req_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
    end
    bus_ack = 1'b0; req_valid = 1'b0;

    for (int k = 0; k < 4; k++) begin
      int d;
      d = (start + k) % 4;
      for (int g = 0; g < gap; g++) begin
        bus_dvalid = 1'b0; bus_data = 64'hFFFF_0000_FFFF_0000;
        #2 chk(lb_we == 1'b0, "R5 no write on wait", 64'(lb_we), 64'd0);
        chk(restart == 1'b0, "R5 no restart on wait", 64'(restart), 64'd0);
        @(posedge clk);
        @(negedge clk);
      end
      bus_dvalid = 1'b1; bus_data = dw_val(line, d);
      #2;
      chk(lb_we == 1'b1, "R3 write strobe", 64'(lb_we), 64'd1);
      chk(lb_idx == d[1:0], "R3 slot order", 64'(lb_idx), 64'(d));
      chk(lb_data == dw_val(line, d), "R3 data", lb_data, dw_val(line, d));
      chk(restart == (k == 0), "R6 restart timing", 64'(restart), 64'(k == 0));
      if (k == 0)
        chk(restart_word == word_val(line, word), "R6 critical word",
            64'(restart_word), 64'(word_val(line, word)));
      chk(line_valid == 1'b0, "R8 no early line_valid", 64'(line_valid), 64'd0);
      if (restart) restarts++;
      if (lb_we) seen[lb_idx] = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    bus_dvalid = 1'b0;
    #2;
    chk(line_valid == 1'b1, "R8 line_valid after last beat", 64'(line_valid), 64'd1);
    chk(req_ready == 1'b0, "R9 not ready with line_valid", 64'(req_ready), 64'd0);
    chk(lb_we == 1'b0, "R10 no fifth write", 64'(lb_we), 64'd0);
    chk(restarts == 1, "R7 one restart per fill", 64'(restarts), 64'd1);
    chk(seen == 4'hF, "R10 every slot once", 64'(seen), 64'hF);
    @(posedge clk);
    @(negedge clk);
    #2;
    chk(line_valid == 1'b0, "R8 single cycle", 64'(line_valid), 64'd0);
    chk(req_ready == 1'b1, "R9 ready again", 64'(req_ready), 64'd1);
    chk(bus_req == 1'b0, "R9 junk ignored", 64'(bus_req), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [26:0] lines [4];
    lines[0] = 27'h0; lines[1] = 27'h7FF_FFFF; lines[2] = 27'h123_4567; lines[3] = 27'h55;
    repeat (3) @(negedge clk);
    // R1 reset state, with stray strobes present
    bus_dvalid = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(bus_req == 1'b0, "R1 bus_req", 64'(bus_req), 64'd0);
    chk(lb_we == 1'b0, "R1 R4 no write when idle", 64'(lb_we), 64'd0);
    chk(restart == 1'b0, "R1 restart", 64'(restart), 64'd0);
    chk(line_valid == 1'b0, "R1 line_valid", 64'(line_valid), 64'd0);
    bus_dvalid = 1'b0;
    for (int li = 0; li < 4; li++)
      for (int w = 0; w < 8; w++)
        run_fill(lines[li], w, (li + w) % 3, (li * 3 + w) % 4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule